// File: doc/BRIEF.md
# Write Enable Latch Controller

This block decides whether a serial memory slave may accept write data. It keeps a single write-permission latch. Enable and disable commands from the command decoder set and clear it. Writes it allows are granted one data byte at a time, and the latch clears itself once a granted write finishes. An active-low protect pin can veto any write, to the memory array or to the status register, whatever state the latch is in.

The command decoder sends single-cycle pulses into the block. These mark an enable command, a disable command, the start of each write data byte (separately for array and status writes), and the end of a write transaction. The decoder raises the end pulse when chip select rises after at least one whole byte. The block returns one grant per target and the status byte for a status read. That byte carries the latch state and a two-bit protect field, which a granted status write updates.

Top module: `wel_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the latch, both grants and all bits of the status byte are 0.
- R2: An enable pulse sets the latch from the next cycle. A disable pulse clears it from the next cycle. When an enable and a disable arrive in the same cycle, the latch ends up clear.
- R3: A byte-start pulse for a target captures (latch AND protect pin high) into that target's grant, which is visible from the next cycle. The grant stays held until that target's end pulse, and reads 0 from the cycle after it.
- R4: The status byte reads the latch at bit 1 and the protect field at bits 3:2. Bits 7:4 and bit 0 always read 0.
- R5: A status write never changes the latch through bit 1 of its data. The latch changes only by being cleared at the end of that write.
- R6: An end pulse for a target clears the latch from the next cycle when at least one byte of that transaction was granted. An end pulse for a transaction with no granted byte leaves the latch unchanged.
- R7: With the protect pin low at a byte start, that byte's grant is 0 for the array and for the status register alike.
- R8: When a status transaction with a granted byte ends, bits 3:2 of the status write data are loaded into the protect field. A status transaction with no granted byte leaves the field unchanged.
- R9: When a clearing event (a disable or a completed granted write) arrives in the same cycle as an enable, the latch ends up clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wren_i | input | 1 | Enable command pulse |
| wrdi_i | input | 1 | Disable command pulse |
| arr_byte_start_i | input | 1 | Start of an array write data byte |
| arr_done_i | input | 1 | End of an array write transaction |
| stat_byte_start_i | input | 1 | Start of a status write data byte |
| stat_done_i | input | 1 | End of a status write transaction |
| stat_wdata_i | input | 8 | Data byte of the status write |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wel_o | output | 1 | Latch state |
| arr_grant_o | output | 1 | Current array byte may be written |
| stat_grant_o | output | 1 | Current status byte may be written |
| status_o | output | 8 | Formatted status byte |

## Verification
Every result of this block is due exactly one clock after the pulse that causes it. The latch, the grants and the protect field are all registered once, and the status byte is a combinational view of those registers. The bench drives its pulses one time unit after a rising edge and updates its behavioural model on the edge. It compares all four outputs against that model at the falling edge, half a period later, so each comparison sees the values that the preceding edge produced. At the points where a corner case resolves (blocked writes, coincident set and clear, status data with bit 1 set), directed checks read the result back at the ports.

// File: rtl/wel_pkg.sv
// Package: shared constants for the write enable latch controller.
// Assumes an 8-bit status byte with the latch flag and protect field at
// fixed positions that the read path of the slave decodes.
package wel_pkg;
    parameter int STAT_W   = 8;
    parameter int WEL_POS  = 1;
    parameter int PROT_LSB = 2;
    parameter int PROT_W   = 2;
    parameter int N_TGT    = 2;
    parameter int TGT_ARR  = 0;
    parameter int TGT_STAT = 1;
endpackage

// File: rtl/wel_latch.sv
// wel_latch: the write permission latch.
// Assumes set and clear are single-cycle pulses; clear dominates set.
module wel_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic wel_o
);
    logic wel_q;

    // Update the latch: clear wins over set, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      wel_q <= 1'b0;
        else if (clr_i)  wel_q <= 1'b0;
        else if (set_i)  wel_q <= 1'b1;
    end

    assign wel_o = wel_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        set_i && !clr_i |=> wel_o);                          // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !wel_o);                                   // R9
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i && !clr_i |=> $stable(wel_o));                // R2
endmodule

// File: rtl/wel_gate.sv
// wel_gate: per-target write grant.
// Samples latch AND protect pin at each byte start, holds it for the byte,
// and reports a commit at transaction end when any byte was granted.
// Assumes end and byte-start pulses come from the command decoder.
module wel_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic byte_start_i,
    input  logic done_i,
    input  logic wel_i,
    input  logic wp_n_i,
    output logic grant_o,
    output logic commit_o
);
    logic grant_q;
    logic seen_q;

    // Capture the grant per byte; the transaction end drops it.
    always_ff @(posedge clk) begin
        if (!rst_n)            grant_q <= 1'b0;
        else if (done_i)       grant_q <= 1'b0;
        else if (byte_start_i) grant_q <= wel_i & wp_n_i;
    end

    // Remember whether any byte of this transaction was granted.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   seen_q <= 1'b0;
        else if (done_i)                              seen_q <= 1'b0;
        else if (byte_start_i && wel_i && wp_n_i)     seen_q <= 1'b1;
    end

    assign grant_o  = grant_q;
    assign commit_o = done_i & seen_q;

    AST_GRANT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_o) |-> $past(wel_i && wp_n_i && byte_start_i)); // R3
    AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_start_i && !wp_n_i |=> !grant_o);               // R7
    AST_GRANT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !grant_o);                                // R3
endmodule

// File: rtl/wel_status_reg.sv
// wel_status_reg: protect field storage and status byte formatting.
// Assumes commit_i pulses only when a granted status write ends; the
// mask keeps the latch position and all unused bits out of storage.
module wel_status_reg
    import wel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [STAT_W-1:0] wdata_i,
    input  logic              wel_i,
    output logic [STAT_W-1:0] status_o
);
    localparam logic [STAT_W-1:0] PROT_MASK =
        STAT_W'(((1 << PROT_W) - 1) << PROT_LSB);

    logic [STAT_W-1:0] prot_q;

    // Load the writable field on a committed status write.
    always_ff @(posedge clk) begin
        if (!rst_n)        prot_q <= '0;
        else if (commit_i) prot_q <= wdata_i & PROT_MASK;
    end

    // Merge the latch flag into the stored field.
    always_comb begin
        status_o = prot_q | (STAT_W'(wel_i) << WEL_POS);
    end

    AST_PROT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (status_o & PROT_MASK) == ($past(wdata_i) & PROT_MASK)); // R8
    AST_PROT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(status_o & PROT_MASK));        // R8
endmodule

// File: rtl/wel_ctrl.sv
// wel_ctrl: top of the write enable latch controller.
// Joins the latch, one grant gate per write target and the status byte.
// Assumes the decoder issues one-cycle pulses and only one command per
// chip-select window.
module wel_ctrl
    import wel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              arr_byte_start_i,
    input  logic              arr_done_i,
    input  logic              stat_byte_start_i,
    input  logic              stat_done_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    input  logic              wp_n_i,
    output logic              wel_o,
    output logic              arr_grant_o,
    output logic              stat_grant_o,
    output logic [STAT_W-1:0] status_o
);
    logic [N_TGT-1:0] bs_vec;
    logic [N_TGT-1:0] done_vec;
    logic [N_TGT-1:0] grant_vec;
    logic [N_TGT-1:0] commit_vec;
    logic             wel;
    logic             clr_any;

    assign bs_vec[TGT_ARR]    = arr_byte_start_i;
    assign bs_vec[TGT_STAT]   = stat_byte_start_i;
    assign done_vec[TGT_ARR]  = arr_done_i;
    assign done_vec[TGT_STAT] = stat_done_i;

    // Any completed granted write or a disable command clears the latch.
    assign clr_any = wrdi_i | (|commit_vec);

    wel_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (wren_i),
        .clr_i (clr_any),
        .wel_o (wel)
    );

    genvar g;
    generate
        for (g = 0; g < N_TGT; g++) begin : g_tgt
            wel_gate u_gate (
                .clk          (clk),
                .rst_n        (rst_n),
                .byte_start_i (bs_vec[g]),
                .done_i       (done_vec[g]),
                .wel_i        (wel),
                .wp_n_i       (wp_n_i),
                .grant_o      (grant_vec[g]),
                .commit_o     (commit_vec[g])
            );
        end
    endgenerate

    wel_status_reg u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit_vec[TGT_STAT]),
        .wdata_i  (stat_wdata_i),
        .wel_i    (wel),
        .status_o (status_o)
    );

    assign wel_o        = wel;
    assign arr_grant_o  = grant_vec[TGT_ARR];
    assign stat_grant_o = grant_vec[TGT_STAT];

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (|commit_vec) |=> !wel_o);                           // R6
    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        wren_i && !clr_any |=> status_o[WEL_POS]);           // R4
    AST_GRANTS_NEED_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i && (arr_byte_start_i || stat_byte_start_i) |=>
            !(arr_grant_o && $rose(arr_grant_o)) && !(stat_grant_o && $rose(stat_grant_o))); // R7
endmodule

// File: tb/wel_ctrl_tb.sv
module wel_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wren = 0, wrdi = 0, abs = 0, adone = 0, sbs = 0, sdone = 0;
    logic [7:0] sdata = 8'h00;
    logic       wp_n = 1'b1;
    logic       wel, agr, sgr;
    logic [7:0] stat;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // behavioural reference state
    int m_wel = 0, m_ag = 0, m_sg = 0, m_aseen = 0, m_sseen = 0, m_prot = 0;

    always #4 clk = ~clk;

    wel_ctrl u_dut (
        .clk (clk), .rst_n (rst_n),
        .wren_i (wren), .wrdi_i (wrdi),
        .arr_byte_start_i (abs), .arr_done_i (adone),
        .stat_byte_start_i (sbs), .stat_done_i (sdone),
        .stat_wdata_i (sdata), .wp_n_i (wp_n),
        .wel_o (wel), .arr_grant_o (agr), .stat_grant_o (sgr),
        .status_o (stat)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // reference model: advances on each rising edge
    always @(posedge clk) begin
        int a_com, s_com, nwel, nag, nsg, nas, nss;
        cyc++;
        if (!rst_n) begin
            m_wel = 0; m_ag = 0; m_sg = 0; m_aseen = 0; m_sseen = 0; m_prot = 0;
        end else begin
            a_com = (adone && m_aseen) ? 1 : 0;
            s_com = (sdone && m_sseen) ? 1 : 0;
            nwel = m_wel; nag = m_ag; nsg = m_sg; nas = m_aseen; nss = m_sseen;
            if (wrdi || a_com || s_com) nwel = 0;
            else if (wren)              nwel = 1;
            if (adone) begin nag = 0; nas = 0; end
            else if (abs) begin nag = m_wel & wp_n; if (nag != 0) nas = 1; end
            if (sdone) begin nsg = 0; nss = 0; end
            else if (sbs) begin nsg = m_wel & wp_n; if (nsg != 0) nss = 1; end
            if (s_com) m_prot = (sdata >> 2) & 3;
            m_wel = nwel; m_ag = nag; m_sg = nsg; m_aseen = nas; m_sseen = nss;
        end
    end

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 latch", wel, m_wel);
            chk("R3 array grant", agr, m_ag);
            chk("R3 status grant", sgr, m_sg);
            chk("R4 status byte", stat, (m_prot << 2) | (m_wel << 1));
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic pulse(input logic p_wren, input logic p_wrdi, input logic p_abs,
                         input logic p_adone, input logic p_sbs, input logic p_sdone);
        wren = p_wren; wrdi = p_wrdi; abs = p_abs; adone = p_adone; sbs = p_sbs; sdone = p_sdone;
        tick(1);
        wren = 0; wrdi = 0; abs = 0; adone = 0; sbs = 0; sdone = 0;
    endtask

    // settle to the next falling edge for a directed read-back
    task automatic look();
        @(negedge clk); #1;
    endtask

    initial begin
        tick(3);
        look();
        chk("R1 latch", wel, 0);
        chk("R1 status", stat, 0);
        chk("R1 grants", {agr, sgr}, 0);
        rst_n = 1'b1;
        tick(2);

        // enable then granted two-byte array write
        pulse(1, 0, 0, 0, 0, 0);
        look(); chk("R2 set", wel, 1); chk("R4 flag", stat, 8'h02);
        pulse(0, 0, 1, 0, 0, 0);
        look(); chk("R3 grant up", agr, 1);
        tick(3);
        pulse(0, 0, 1, 0, 0, 0);
        tick(3);
        pulse(0, 0, 0, 1, 0, 0);
        look(); chk("R6 cleared", wel, 0); chk("R3 grant down", agr, 0);

        // array write without enable
        pulse(0, 0, 1, 0, 0, 0);
        look(); chk("R3 no latch", agr, 0);
        pulse(0, 0, 0, 1, 0, 0);

        // protect pin low, latch set: blocked, latch kept
        pulse(1, 0, 0, 0, 0, 0);
        wp_n = 0;
        pulse(0, 0, 1, 0, 0, 0);
        look(); chk("R7 array blocked", agr, 0);
        pulse(0, 0, 0, 1, 0, 0);
        look(); chk("R6 blocked keeps", wel, 1);
        sdata = 8'hFF;
        pulse(0, 0, 0, 0, 1, 0);
        look(); chk("R7 status blocked", sgr, 0);
        pulse(0, 0, 0, 0, 0, 1);
        look(); chk("R8 field kept", stat, 8'h02);
        wp_n = 1;
        pulse(0, 1, 0, 0, 0, 0);
        look(); chk("R2 disable", wel, 0);

        // granted status write with bit 1 set in data
        pulse(1, 0, 0, 0, 0, 0);
        sdata = 8'hFF;
        pulse(0, 0, 0, 0, 1, 0);
        look(); chk("R3 status grant up", sgr, 1);
        tick(2);
        pulse(0, 0, 0, 0, 0, 1);
        look(); chk("R8 field loaded", stat, 8'h0C); chk("R5 latch not written", wel, 0);

        // status write without latch
        sdata = 8'h00;
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 0, 0, 1);
        look(); chk("R8 no latch no load", stat, 8'h0C);

        // status write with only bit 1 in data
        pulse(1, 0, 0, 0, 0, 0);
        sdata = 8'h02;
        pulse(0, 0, 0, 0, 1, 0);
        pulse(0, 0, 0, 0, 0, 1);
        look(); chk("R5 bit1 ignored", stat, 8'h00);

        // enable and disable together
        pulse(1, 1, 0, 0, 0, 0);
        look(); chk("R2 both", wel, 0);

        // first byte granted, second blocked, completion still clears
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 0, 1, 0, 0, 0);
        wp_n = 0;
        pulse(0, 0, 1, 0, 0, 0);
        look(); chk("R7 second byte blocked", agr, 0);
        wp_n = 1;
        pulse(0, 0, 0, 1, 0, 0);
        look(); chk("R6 partial clears", wel, 0);

        // enable coincides with a completing granted write
        pulse(1, 0, 0, 0, 0, 0);
        pulse(0, 0, 1, 0, 0, 0);
        pulse(1, 0, 0, 1, 0, 0);
        look(); chk("R9 clear wins", wel, 0);

        // reset mid-state
        pulse(1, 0, 0, 0, 0, 0);
        rst_n = 0;
        tick(1);
        look(); chk("R1 reset again", {wel, agr, sgr}, 0);
        rst_n = 1;
        tick(3);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule